// File: doc/BRIEF.md
# Windowed Oscillator Frequency Counter

This block turns the rate of a slow, free-running oscillator into a binary code. Software or a sequencer in the reference-clock domain gives a start pulse and a window length counted in reference cycles. The block opens a gate for that many reference cycles. The oscillator domain counts its own rising edges while it sees the gate open. When the gate closes, the count is frozen and handed back to the reference domain. Because the window has a fixed duration, the code is proportional to the oscillator frequency. A sensor that drives its oscillator from a temperature-dependent current can therefore read temperature from it, after a separate calibration step.

Every conversion clears both counters first. The reference counter is cleared when a start is accepted. The oscillator counter is cleared while the gate is seen closed. The gate opening and closing cross into the oscillator domain through a two-flop synchroniser. The oscillator side echoes the gate back through a second synchroniser, and this echo acts as a four-phase acknowledge. The frozen count is copied only after the echo has dropped, so it has been stable for at least two reference cycles when it is read.

Top module: `freq_window_meter`

## Requirements
- R1: While `ref_rst` is high and after it drops, before any conversion, `done_o` and `code_valid_o` are 0 and `code_o` is 0.
- R2: After an accepted start, `code_o` equals the number of oscillator periods that fit in `win_len_i` reference periods, within one count either way.
- R3: The oscillator count stops at 65535 (all ones) and never wraps, so a window holding more periods than that reports 65535.
- R4: A start pulse during a conversion is ignored. It does not restart the window, and a `win_len_i` value presented with it is not used. The result reflects the length sampled at the accepted start.
- R5: In the cycle after an accepted start, `done_o` is 0. It stays 0 until the result is ready, then rises together with a `code_valid_o` pulse of exactly one cycle. That pulse occurs exactly once per conversion.
- R6: The window stays open until the oscillator side has acknowledged the opening. A conversion with a length of 0 or 1 therefore always completes, and it reports a small code (at most 8 with a 40 ns oscillator and a 10 ns reference).
- R7: The oscillator count is cleared before each conversion, so a result never includes edges counted in an earlier window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock that times the window |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain (also synchronised into the oscillator domain) |
| osc_clk | input | 1 | Oscillator to be measured |
| start_i | input | 1 | One-cycle conversion request, accepted only when idle |
| win_len_i | input | 16 | Window length in reference cycles, sampled at an accepted start |
| done_o | output | 1 | High when a result is held and no conversion runs |
| code_valid_o | output | 1 | One-cycle pulse when `code_o` is updated |
| code_o | output | 16 | Oscillator periods counted in the last window |

## Verification
The gate is open for exactly `win_len_i` reference cycles once the echo has arrived. After it closes, the result appears about two oscillator periods plus three reference cycles later. That delay depends on the phase of the two clocks, so the bench does not sample the code at a fixed cycle. It drives start at a falling edge and checks `done_o` at the next falling edge, exactly one cycle later. It then polls `done_o` at each falling edge under a bound, and it counts `code_valid_o` pulses over that poll and over a few further cycles. Codes are compared against a window computed from the requirement, with one count of slack for the synchronisers.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;

    localparam int CNT_W = 16;
    localparam int WIN_W = 16;
    localparam int SYNC_STAGES = 2;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_DRAIN = 2'd2
    } win_state_e;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/osc_edge_counter.sv
module osc_edge_counter
    import freq_meter_pkg::*;
(
    input  logic             osc_clk,
    input  logic             osc_rst,
    input  logic             gate_s,
    output logic             seen_o,
    output logic [CNT_W-1:0] hold_o
);
    logic [CNT_W-1:0] cnt;
    logic             capture;

    assign capture = !gate_s && seen_o;

    always_ff @(posedge osc_clk) begin
        if (osc_rst) begin
            cnt    <= '0;
            seen_o <= 1'b0;
            hold_o <= '0;
        end else begin
            seen_o <= gate_s;
            if (gate_s)       cnt <= sat_inc(cnt);
            else              cnt <= '0;
            if (capture)      hold_o <= cnt;
        end
    end

    p_no_wrap_r3: assert property (@(posedge osc_clk) disable iff (osc_rst)
        (gate_s && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    p_clear_idle_r7: assert property (@(posedge osc_clk) disable iff (osc_rst)
        (!gate_s && !seen_o) |=> (cnt == '0));

    p_hold_frozen_r6: assert property (@(posedge osc_clk) disable iff (osc_rst)
        !capture |=> $stable(hold_o));
endmodule

// File: rtl/window_timer.sv
module window_timer
    import freq_meter_pkg::*;
(
    input  logic             ref_clk,
    input  logic             ref_rst,
    input  logic             start_i,
    input  logic [WIN_W-1:0] win_len_i,
    input  logic             echo_s,
    input  logic [CNT_W-1:0] hold_i,
    output logic             gate_o,
    output logic             done_o,
    output logic             valid_o,
    output logic [CNT_W-1:0] code_o
);
    win_state_e       state;
    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] tick;
    logic             span_end;

    assign span_end = ({1'b0, tick} + 17'd1) >= {1'b0, win_q};

    always_ff @(posedge ref_clk) begin
        if (ref_rst) begin
            state   <= ST_IDLE;
            win_q   <= '0;
            tick    <= '0;
            gate_o  <= 1'b0;
            done_o  <= 1'b0;
            valid_o <= 1'b0;
            code_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            case (state)
                ST_IDLE: if (start_i) begin
                    win_q  <= win_len_i;
                    tick   <= '0;
                    gate_o <= 1'b1;
                    done_o <= 1'b0;
                    state  <= ST_OPEN;
                end
                ST_OPEN: begin
                    tick <= (tick == {WIN_W{1'b1}}) ? tick : tick + 1'b1;
                    if (span_end && echo_s) begin
                        gate_o <= 1'b0;
                        state  <= ST_DRAIN;
                    end
                end
                ST_DRAIN: if (!echo_s) begin
                    code_o  <= hold_i;
                    valid_o <= 1'b1;
                    done_o  <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_start_clears_done_r5: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (start_i && state == ST_IDLE) |=> (!done_o && gate_o));

    p_valid_single_r5: assert property (@(posedge ref_clk) disable iff (ref_rst)
        valid_o |=> !valid_o);

    p_valid_with_done_r5: assert property (@(posedge ref_clk) disable iff (ref_rst)
        valid_o |-> done_o);

    p_len_locked_r4: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (state != ST_IDLE) |=> $stable(win_q));

    p_close_after_echo_r6: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (state == ST_OPEN && !echo_s) |=> gate_o);
endmodule

// File: rtl/freq_window_meter.sv
module freq_window_meter
    import freq_meter_pkg::*;
(
    input  logic             ref_clk,
    input  logic             ref_rst,
    input  logic             osc_clk,
    input  logic             start_i,
    input  logic [WIN_W-1:0] win_len_i,
    output logic             done_o,
    output logic             code_valid_o,
    output logic [CNT_W-1:0] code_o
);
    logic             osc_rst;
    logic             gate;
    logic             gate_s;
    logic             seen;
    logic             echo_s;
    logic [CNT_W-1:0] hold;

    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
        .clk(osc_clk), .rst(1'b0), .d(ref_rst), .q(osc_rst)
    );

    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_gate_sync (
        .clk(osc_clk), .rst(osc_rst), .d(gate), .q(gate_s)
    );

    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_echo_sync (
        .clk(ref_clk), .rst(ref_rst), .d(seen), .q(echo_s)
    );

    osc_edge_counter u_osc_cnt (
        .osc_clk(osc_clk), .osc_rst(osc_rst), .gate_s(gate_s),
        .seen_o(seen), .hold_o(hold)
    );

    window_timer u_timer (
        .ref_clk(ref_clk), .ref_rst(ref_rst), .start_i(start_i),
        .win_len_i(win_len_i), .echo_s(echo_s), .hold_i(hold),
        .gate_o(gate), .done_o(done_o), .valid_o(code_valid_o), .code_o(code_o)
    );
endmodule

// File: tb/tb_freq_window_meter.sv
`timescale 1ns/1ps
module tb_freq_window_meter;
    localparam int TCLK = 10;
    localparam int NVEC = 6;
    localparam int MAXC = 65535;
    // each entry: {window length in reference cycles, oscillator period in ns}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'd200,   16'd40},
        {16'd400,   16'd50},
        {16'd1000,  16'd80},
        {16'd999,   16'd130},
        {16'd65535, 16'd160},
        {16'd30000, 16'd4}
    };

    logic        ref_clk = 1'b0;
    logic        osc_clk = 1'b0;
    logic        ref_rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] win_len_i = '0;
    logic        done_o;
    logic        code_valid_o;
    logic [15:0] code_o;
    realtime     osc_half = 20.0;

    int n_chk = 0;
    int n_bad = 0;

    freq_window_meter dut (
        .ref_clk(ref_clk), .ref_rst(ref_rst), .osc_clk(osc_clk),
        .start_i(start_i), .win_len_i(win_len_i), .done_o(done_o),
        .code_valid_o(code_valid_o), .code_o(code_o)
    );

    always #(TCLK/2) ref_clk = ~ref_clk;
    always #(osc_half) osc_clk = ~osc_clk;

    task automatic chk(input bit ok, input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        chk(act >= lo && act <= hi, tag, act, lo, hi);
    endtask

    // start a conversion, wait for done, return code and valid-pulse count
    task automatic convert(input int win, output int code, output int nval, output bit drop_ok);
        nval = 0;
        @(negedge ref_clk);
        win_len_i = win[15:0];
        start_i   = 1'b1;
        @(negedge ref_clk);
        start_i   = 1'b0;
        drop_ok   = !done_o;
        if (code_valid_o) nval++;
        for (int i = 0; i < 70000 && !done_o; i++) begin
            @(negedge ref_clk);
            if (code_valid_o) nval++;
        end
        code = int'(code_o);
        for (int i = 0; i < 6; i++) begin
            @(negedge ref_clk);
            if (code_valid_o) nval++;
        end
    endtask

    function automatic int exp_lo(input int win, input int tosc);
        int e = (win * TCLK) / tosc - 1;
        return (e > MAXC) ? MAXC : e;
    endfunction

    function automatic int exp_hi(input int win, input int tosc);
        int e = (win * TCLK + tosc - 1) / tosc + 1;
        return (e > MAXC) ? MAXC : e;
    endfunction

    initial begin
        #(190000 * TCLK);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int code;
        int nval;
        bit drop_ok;

        repeat (10) @(negedge ref_clk);
        // R1: outputs during reset
        chk(!done_o && !code_valid_o && code_o == 0, "R1 in reset",
            int'(code_o) + int'(done_o) + int'(code_valid_o), 0, 0);
        ref_rst = 1'b0;
        repeat (8) @(negedge ref_clk);
        chk(!done_o, "R1 done after reset", int'(done_o), 0, 0);
        chk(!code_valid_o, "R1 valid after reset", int'(code_valid_o), 0, 0);
        chk(code_o == 0, "R1 code after reset", int'(code_o), 0, 0);

        // R2/R3/R7: table walk; later entries prove counts are cleared (R7)
        for (int v = 0; v < NVEC; v++) begin
            int win  = int'(VEC[v][31:16]);
            int tosc = int'(VEC[v][15:0]);
            osc_half = tosc / 2.0;
            repeat (4) @(negedge ref_clk);
            convert(win, code, nval, drop_ok);
            if (win * TCLK / tosc > MAXC)
                chk(code == MAXC, "R3 saturated code", code, MAXC, MAXC);
            else
                chk_rng((v > 0) ? "R2 R7 window code" : "R2 window code",
                        code, exp_lo(win, tosc), exp_hi(win, tosc));
            chk(drop_ok, "R5 done low after start", int'(!drop_ok), 0, 0);
            chk(nval == 1, "R5 one valid pulse", nval, 1, 1);
        end

        // R4: second start with a new length mid-conversion is ignored
        osc_half = 20.0;
        repeat (4) @(negedge ref_clk);
        @(negedge ref_clk);
        win_len_i = 16'd400;
        start_i   = 1'b1;
        @(negedge ref_clk);
        start_i   = 1'b0;
        repeat (100) @(negedge ref_clk);
        win_len_i = 16'd100;
        start_i   = 1'b1;
        @(negedge ref_clk);
        start_i   = 1'b0;
        nval = 0;
        for (int i = 0; i < 2000 && !done_o; i++) begin
            @(negedge ref_clk);
            if (code_valid_o) nval++;
        end
        code = int'(code_o);
        repeat (6) begin
            @(negedge ref_clk);
            if (code_valid_o) nval++;
        end
        chk_rng("R4 busy start ignored", code, exp_lo(400, 40), exp_hi(400, 40));
        chk(nval == 1, "R4 single result", nval, 1, 1);

        // R5: code held while idle
        repeat (20) @(negedge ref_clk);
        chk(int'(code_o) == code && done_o, "R5 result held", int'(code_o), code, code);

        // R6: zero and one length windows complete with a small code
        convert(0, code, nval, drop_ok);
        chk(done_o, "R6 zero window completes", int'(done_o), 1, 1);
        chk_rng("R6 zero window code", code, 0, 8);
        convert(1, code, nval, drop_ok);
        chk_rng("R6 one-cycle window code", code, 0, 8);
        chk(nval == 1, "R6 one-cycle valid", nval, 1, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule